// File: doc/BRIEF.md
# Wake Event Controller

This block turns a set of wake sources into one power-management wake request for the chipset. The sources are two active-low ring-indicator inputs, keyboard and mouse data lines, a group of general-purpose inputs, a fan-tachometer event and a device-interrupt line that comes from the system-management logic. Every source passes through a two-flop synchroniser and an edge detector. A detected edge latches a per-source status bit, and that bit stays set until software writes 1 to it.

A small register port gives access to the status bits, the per-source enables, a global enable, the pin polarity and the pin drive type. The wake request is asserted only while the global enable is set and at least one latched status bit has its own enable set. The pin is modelled as a data value plus an output-enable, so the same logic covers open-drain and push-pull drive.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After reset all status bits, source enables, the global enable, the GPIO edge settings and the pin settings read 0, which gives open-drain, active-low drive, and `wake_oe` is 0.
- R2: A falling edge on `ri1_n` sets status bit 0, and a falling edge on `ri2_n` sets status bit 1. Rising edges on these inputs set nothing.
- R3: A falling edge on `kbd_data` sets status bit 2, and a falling edge on `mouse_data` sets status bit 3. Rising edges on these inputs set nothing.
- R4: A rising edge on `tach_evt` sets status bit 4, and a rising edge on `devint` sets status bit 5. Falling edges on these inputs set nothing.
- R5: A rising edge on `gpio_in[i]` sets status bit 6+i. Bit i of register 4 set to 1 selects the falling edge instead. Bit 8+i of register 4 set to 1 selects both edges and takes priority over bit i.
- R6: Status bits are set by source edges whether the global enable is set or clear.
- R7: Writing register 0 clears each status bit whose data bit is 1 and leaves the others unchanged. A source edge that lands in the same cycle as the clear wins, and the bit stays set.
- R8: Bit 8 of register 2 is read-only. It reads as the OR over all sources of (status AND enable, with the enable from register 1 bit n). It does not depend on the global enable, and it stays 1 until every enabled pending status bit has been cleared.
- R9: The wake request is asserted exactly when global enable (register 2 bit 0) is 1 and the summary of R8 is 1.
- R10: Register 3 bit 2 selects the active level: 0 means active low and 1 means active high.
- R11: Register 3 bit 7 selects the drive. With 0 (open-drain), `wake_oe` is 1 only while the request is asserted, and `wake_o` is then the active level. With 1 (push-pull), `wake_oe` is always 1 and `wake_o` shows the request at the selected level.
- R12: A source input change made before a clock edge sets its status bit on the third rising clock edge, counting that edge as the first, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ri1_n | input | 1 | Ring indicator 1, active low |
| ri2_n | input | 1 | Ring indicator 2, active low |
| kbd_data | input | 1 | Keyboard data line |
| mouse_data | input | 1 | Mouse data line |
| gpio_in | input | NGPIO | General-purpose wake inputs |
| tach_evt | input | 1 | Fan tachometer event |
| devint | input | 1 | Device interrupt from system-management logic |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 status, 1 enables, 2 control, 3 pin, 4 GPIO edge) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on `reg_addr` |
| wake_o | output | 1 | Wake pin data value |
| wake_oe | output | 1 | Wake pin output-enable |

## Verification
A wrong status bit shows up in the status register read three clocks after the source edge. If that bit is enabled, it also shows up in the same cycle in the summary bit, and with the global enable set it reaches `wake_oe` or `wake_o`. A wrong polarity or drive-type register shows at the pin immediately, but only in the matching asserted or idle state, so both states are driven in every pin mode. A clear that overrides a set in the same cycle hides until the next read, so the collision is placed on an exact edge.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_mode_e;

  // fixed source slots, GPIOs follow
  localparam int SRC_RI1    = 0;
  localparam int SRC_RI2    = 1;
  localparam int SRC_KBD    = 2;
  localparam int SRC_MSE    = 3;
  localparam int SRC_TACH   = 4;
  localparam int SRC_DEV    = 5;
  localparam int FIXED_SRCS = 6;

  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_STS  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_EN   = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_PIN  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_GPIO = 3'd4;

  localparam int CTRL_GEN_BIT = 0;
  localparam int CTRL_SUM_BIT = 8;
  localparam int PIN_POL_BIT  = 2;
  localparam int PIN_DRV_BIT  = 7;
  localparam int GPIO_BOTH_LSB = 8;

  // detect the selected transition between two consecutive samples
  function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // edge mode for a GPIO slot from its two configuration bits
  function automatic edge_mode_e gpio_mode(logic fall_sel, logic both_sel);
    if (both_sel)      gpio_mode = EDGE_BOTH;
    else if (fall_sel) gpio_mode = EDGE_FALL;
    else               gpio_mode = EDGE_RISE;
  endfunction

  // pin model: returns {oe, data}
  function automatic logic [1:0] pin_drive(logic act, logic pol_high, logic push_pull);
    logic oe, dat;
    if (push_pull) begin
      oe  = 1'b1;
      dat = pol_high ? act : ~act;
    end else begin
      oe  = act;
      dat = pol_high;
    end
    pin_drive = {oe, dat};
  endfunction

endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det
  import wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  edge_mode_e mode,
  output logic       hit
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], din};
  end

  assign hit = edge_hit(mode, chain_q[SYNC_STAGES-1], chain_q[SYNC_STAGES]);

endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_evt,
  input  logic [NSRC-1:0] clr_mask,
  output logic [NSRC-1:0] sts_q
);
  // a new edge beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_mask) | set_evt;
  end

endmodule

// File: rtl/wake_reg_file.sv
module wake_reg_file
  import wake_pkg::*;
#(
  parameter int NSRC  = 10,
  parameter int NGPIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [NSRC-1:0]   sts_q,
  input  logic              summary,
  output logic [NSRC-1:0]   clr_mask,
  output logic [NSRC-1:0]   en_q,
  output logic              gen_q,
  output logic              pol_q,
  output logic              pp_q,
  output logic [NGPIO-1:0]  gpio_fall_q,
  output logic [NGPIO-1:0]  gpio_both_q
);
  logic wr_sts, wr_en, wr_ctrl, wr_pin, wr_gpio;

  assign wr_sts  = reg_we && (reg_addr == ADDR_STS);
  assign wr_en   = reg_we && (reg_addr == ADDR_EN);
  assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
  assign wr_pin  = reg_we && (reg_addr == ADDR_PIN);
  assign wr_gpio = reg_we && (reg_addr == ADDR_GPIO);

  assign clr_mask = wr_sts ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= '0;
      gen_q       <= 1'b0;
      pol_q       <= 1'b0;
      pp_q        <= 1'b0;
      gpio_fall_q <= '0;
      gpio_both_q <= '0;
    end else begin
      if (wr_en)   en_q  <= reg_wdata[NSRC-1:0];
      if (wr_ctrl) gen_q <= reg_wdata[CTRL_GEN_BIT];
      if (wr_pin) begin
        pol_q <= reg_wdata[PIN_POL_BIT];
        pp_q  <= reg_wdata[PIN_DRV_BIT];
      end
      if (wr_gpio) begin
        gpio_fall_q <= reg_wdata[NGPIO-1:0];
        gpio_both_q <= reg_wdata[GPIO_BOTH_LSB +: NGPIO];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_STS:  reg_rdata[NSRC-1:0] = sts_q;
      ADDR_EN:   reg_rdata[NSRC-1:0] = en_q;
      ADDR_CTRL: begin
        reg_rdata[CTRL_GEN_BIT] = gen_q;
        reg_rdata[CTRL_SUM_BIT] = summary;
      end
      ADDR_PIN: begin
        reg_rdata[PIN_POL_BIT] = pol_q;
        reg_rdata[PIN_DRV_BIT] = pp_q;
      end
      ADDR_GPIO: begin
        reg_rdata[NGPIO-1:0]             = gpio_fall_q;
        reg_rdata[GPIO_BOTH_LSB +: NGPIO] = gpio_both_q;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wake_pin_drive.sv
module wake_pin_drive
  import wake_pkg::*;
#(
  parameter int NSRC = 10
) (
  input  logic [NSRC-1:0] sts_q,
  input  logic [NSRC-1:0] en_q,
  input  logic            gen_q,
  input  logic            pol_q,
  input  logic            pp_q,
  output logic            summary,
  output logic            wake_assert,
  output logic            wake_o,
  output logic            wake_oe
);
  logic [1:0] drv;

  assign summary     = |(sts_q & en_q);
  assign wake_assert = gen_q & summary;
  assign drv         = pin_drive(wake_assert, pol_q, pp_q);
  assign wake_oe     = drv[1];
  assign wake_o      = drv[0];

endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int NGPIO       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ri1_n,
  input  logic              ri2_n,
  input  logic              kbd_data,
  input  logic              mouse_data,
  input  logic [NGPIO-1:0]  gpio_in,
  input  logic              tach_evt,
  input  logic              devint,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              wake_o,
  output logic              wake_oe
);
  localparam int NSRC = FIXED_SRCS + NGPIO;

  logic [NSRC-1:0]  src_raw;
  logic [NSRC-1:0]  set_evt;
  logic [NSRC-1:0]  clr_mask;
  logic [NSRC-1:0]  sts_q;
  logic [NSRC-1:0]  en_q;
  logic             gen_q, pol_q, pp_q;
  logic             summary, wake_assert;
  logic [NGPIO-1:0] gpio_fall_q, gpio_both_q;
  edge_mode_e       mode_v [NSRC];

  assign src_raw[SRC_RI1]  = ri1_n;
  assign src_raw[SRC_RI2]  = ri2_n;
  assign src_raw[SRC_KBD]  = kbd_data;
  assign src_raw[SRC_MSE]  = mouse_data;
  assign src_raw[SRC_TACH] = tach_evt;
  assign src_raw[SRC_DEV]  = devint;
  assign src_raw[NSRC-1:FIXED_SRCS] = gpio_in;

  assign mode_v[SRC_RI1]  = EDGE_FALL;
  assign mode_v[SRC_RI2]  = EDGE_FALL;
  assign mode_v[SRC_KBD]  = EDGE_FALL;
  assign mode_v[SRC_MSE]  = EDGE_FALL;
  assign mode_v[SRC_TACH] = EDGE_RISE;
  assign mode_v[SRC_DEV]  = EDGE_RISE;

  for (genvar g = 0; g < NGPIO; g++) begin : g_gpio_mode
    assign mode_v[FIXED_SRCS+g] = gpio_mode(gpio_fall_q[g], gpio_both_q[g]);
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    wake_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_raw[s]),
      .mode (mode_v[s]),
      .hit  (set_evt[s])
    );
  end

  wake_status_bank #(.NSRC(NSRC)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_mask(clr_mask),
    .sts_q   (sts_q)
  );

  wake_reg_file #(.NSRC(NSRC), .NGPIO(NGPIO)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sts_q      (sts_q),
    .summary    (summary),
    .clr_mask   (clr_mask),
    .en_q       (en_q),
    .gen_q      (gen_q),
    .pol_q      (pol_q),
    .pp_q       (pp_q),
    .gpio_fall_q(gpio_fall_q),
    .gpio_both_q(gpio_both_q)
  );

  wake_pin_drive #(.NSRC(NSRC)) u_pin (
    .sts_q      (sts_q),
    .en_q       (en_q),
    .gen_q      (gen_q),
    .pol_q      (pol_q),
    .pp_q       (pp_q),
    .summary    (summary),
    .wake_assert(wake_assert),
    .wake_o     (wake_o),
    .wake_oe    (wake_oe)
  );

endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk
  import wake_pkg::*;
#(
  parameter int NSRC = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [NSRC-1:0]   set_evt,
  input logic [NSRC-1:0]   sts_q,
  input logic              gen_q,
  input logic              pol_q,
  input logic              pp_q,
  input logic              wake_assert,
  input logic              wake_o,
  input logic              wake_oe
);
  // R6
  evt_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((sts_q & $past(set_evt)) == $past(set_evt)));

  // R7
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_we && reg_addr == ADDR_STS) && set_evt == '0) |=> $stable(sts_q));

  // R9
  gen_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && !pp_q) |-> !wake_oe);

  // R10
  od_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_q && wake_assert) |-> (wake_oe && wake_o == pol_q));

  // R11
  pp_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_q |-> wake_oe);

  // R11
  od_idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pp_q && !wake_assert) |-> !wake_oe);

endmodule

bind wake_evt_ctrl wake_evt_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .set_evt    (set_evt),
  .sts_q      (sts_q),
  .gen_q      (gen_q),
  .pol_q      (pol_q),
  .pp_q       (pp_q),
  .wake_assert(wake_assert),
  .wake_o     (wake_o),
  .wake_oe    (wake_oe)
);

// File: tb/wake_evt_ctrl_tb_top.sv
module wake_evt_ctrl_tb_top;
  localparam int NGPIO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ri1_n = 1'b1, ri2_n = 1'b1, kbd_data = 1'b1, mouse_data = 1'b1;
  logic [NGPIO-1:0] gpio_in = '0;
  logic        tach_evt = 1'b0, devint = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wake_o, wake_oe;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  wake_evt_ctrl #(.NGPIO(NGPIO)) dut_i (
    .clk(clk), .rst_n(rst_n), .ri1_n(ri1_n), .ri2_n(ri2_n),
    .kbd_data(kbd_data), .mouse_data(mouse_data), .gpio_in(gpio_in),
    .tach_evt(tach_evt), .devint(devint), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_o(wake_o), .wake_oe(wake_oe)
  );

  // {inputs {gpio[3:0],devint,tach,mouse,kbd,ri2_n,ri1_n}, expected status}
  localparam logic [19:0] VEC [0:8] = '{
    {10'h00E, 10'h001},  // R2 ri1 falls
    {10'h00F, 10'h000},  // R2 ri1 rises, ignored
    {10'h009, 10'h006},  // R2 R3 ri2 and kbd fall
    {10'h001, 10'h008},  // R3 mouse falls
    {10'h01F, 10'h010},  // R4 tach rises, others rise ignored
    {10'h02F, 10'h020},  // R4 devint rises, tach fall ignored
    {10'h3EF, 10'h340},  // R5 gpio rise: 0 rise,2 both,3 rise
    {10'h02F, 10'h180},  // R5 gpio fall: 1 fall,2 both
    {10'h00F, 10'h000}   // R4 devint falls, ignored
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [9:0] v);
    ri1_n = v[0]; ri2_n = v[1]; kbd_data = v[2]; mouse_data = v[3];
    tach_evt = v[4]; devint = v[5]; gpio_in = v[9:6];
  endtask

  // tasks start and end just after a falling clock edge
  task automatic reg_wr(logic [2:0] a, logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(3);

    // R1 reset state
    reg_rd(3'd0, rv); check("R1 status", rv, 16'h0000);
    reg_rd(3'd1, rv); check("R1 enable", rv, 16'h0000);
    reg_rd(3'd2, rv); check("R1 ctrl", rv, 16'h0000);
    reg_rd(3'd3, rv); check("R1 pin", rv, 16'h0000);
    reg_rd(3'd4, rv); check("R1 gpio cfg", rv, 16'h0000);
    check("R1 wake_oe", {15'd0, wake_oe}, 16'h0000);

    // R5 gpio1 falling, gpio2 both
    reg_wr(3'd4, 16'h0402);
    reg_rd(3'd4, rv); check("R5 gpio cfg readback", rv, 16'h0402);

    // vector table, global enable clear throughout (R6)
    for (int k = 0; k < 9; k++) begin
      apply(VEC[k][19:10]);
      cycles(4);
      reg_rd(3'd0, rv);
      check($sformatf("R6 vector %0d status", k), rv, {6'd0, VEC[k][9:0]});
      reg_wr(3'd0, 16'h03FF);
      cycles(1);
    end
    reg_rd(3'd0, rv); check("R7 clear all", rv, 16'h0000);

    // R12 latency: not set after two edges, set on the third
    ri1_n = 1'b0;
    cycles(2);
    reg_rd(3'd0, rv); check("R12 early", rv, 16'h0000);
    cycles(1);
    reg_rd(3'd0, rv); check("R12 on time", rv, 16'h0001);
    ri1_n = 1'b1;
    reg_wr(3'd0, 16'h0001);

    // R7 set and clear in the same cycle: set wins
    ri2_n = 1'b0;
    cycles(2);
    reg_wr(3'd0, 16'h0002);
    reg_rd(3'd0, rv); check("R7 set beats clear", rv, 16'h0002);
    ri2_n = 1'b1;
    reg_wr(3'd0, 16'h0002);
    cycles(3);

    // R8 / R9 / R10 / R11
    reg_wr(3'd1, 16'h0003);
    ri1_n = 1'b0; ri2_n = 1'b0;
    cycles(4);
    reg_rd(3'd2, rv); check("R8 summary without global enable", rv, 16'h0100);
    check("R9 no drive with global enable clear", {15'd0, wake_oe}, 16'h0000);
    reg_wr(3'd2, 16'h0001);
    check("R11 open-drain active low oe/o", {14'd0, wake_oe, wake_o}, 16'h0002);
    reg_wr(3'd3, 16'h0004);
    check("R10 open-drain active high oe/o", {14'd0, wake_oe, wake_o}, 16'h0003);
    reg_wr(3'd3, 16'h0080);
    check("R11 push-pull active low asserted", {14'd0, wake_oe, wake_o}, 16'h0002);
    reg_wr(3'd0, 16'h0001);
    reg_rd(3'd2, rv); check("R8 summary holds with one pending", rv, 16'h0101);
    reg_wr(3'd0, 16'h0002);
    reg_rd(3'd2, rv); check("R8 summary clears after last", rv, 16'h0001);
    check("R11 push-pull active low idle", {14'd0, wake_oe, wake_o}, 16'h0003);
    reg_wr(3'd3, 16'h0084);
    check("R10 push-pull active high idle", {14'd0, wake_oe, wake_o}, 16'h0002);
    reg_wr(3'd3, 16'h0000);
    check("R11 open-drain idle released", {15'd0, wake_oe}, 16'h0000);
    ri1_n = 1'b1; ri2_n = 1'b1;

    // R8 disabled source does not count
    kbd_data = 1'b0;
    cycles(4);
    reg_rd(3'd2, rv); check("R8 disabled source", rv, 16'h0001);
    check("R9 disabled source no drive", {15'd0, wake_oe}, 16'h0000);
    reg_wr(3'd1, 16'h0004);
    reg_rd(3'd2, rv); check("R8 enable pending source", rv, 16'h0101);
    check("R9 drive after enable", {14'd0, wake_oe, wake_o}, 16'h0002);

    // R7 writing zero leaves status unchanged
    reg_wr(3'd0, 16'h0000);
    reg_rd(3'd0, rv); check("R7 write zero keeps", rv, 16'h0004);
    kbd_data = 1'b1;

    finish_run();
  end

endmodule